// File: doc/BRIEF.md
# Two-Level Page Translator with Translation Cache

The block turns 32-bit linear addresses into 32-bit physical addresses. When paging is off, the physical address equals the linear address. When paging is on, the block first looks the page number up in a 32-entry fully associative translation cache. On a hit it answers the cycle after the request. On a miss it reads a directory entry and then a table entry through a single 32-bit memory read port, stores the result in the cache and answers.

An entry whose present bit is clear, at either level, ends the walk with a fault response. The faulting linear address is then kept in a dedicated register until the next fault. A flush strobe empties the cache. Only one request is handled at a time: `req_ready` is low while a walk is in progress.

Top module: `pw_translator`

## Requirements
- R1: With `paging_en` low, an accepted request yields `rsp_valid` on the next cycle with `rsp_phys` equal to `req_lin`, `rsp_fault` low and no memory read.
- R2: A linear address splits into bits [31:22] directory index, [21:12] table index and [11:0] offset. The first read of a walk goes to `{dir_base[31:12], directory index, 2'b00}`, and `dir_base[11:0]` is ignored.
- R3: The second read of a walk goes to `{directory entry[31:12], table index, 2'b00}`.
- R4: A completed walk answers with `rsp_phys = {table entry[31:12], offset}`, ignores entry bits [11:1] and installs the translation in the cache.
- R5: A cache hit answers on the cycle after acceptance, with no memory read, for any offset within the cached page.
- R6: Bit 0 of each entry is its present bit. If it is 0 at the first level, the walk stops after one read; if it is 0 at the second level, after two reads. Either way the response has `rsp_fault` high and `fault_addr` takes the linear address. Nothing is cached, and `fault_addr` holds its value until the next fault.
- R7: The cache holds 32 translations and replaces entries in round-robin order, starting from slot 0 after reset or flush.
- R8: A one-cycle `flush` invalidates every cache entry and returns the replacement pointer to slot 0.
- R9: Each memory read is a one-cycle `mem_rd_en` pulse. `req_ready` is low from acceptance of a missing request until its response.
- R10: After reset `req_ready` is high, `rsp_valid` and `mem_rd_en` are low and `fault_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | Translation enable |
| dir_base | input | 32 | Directory base register; bits [31:12] used |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_lin | input | 32 | Linear address of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_phys | output | 32 | Translated physical address |
| fault_addr | output | 32 | Linear address of the most recent fault |
| mem_rd_en | output | 1 | Memory read request pulse |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | 32 | Memory read data |

## Verification
Properties check on every cycle:
- the one-cycle pass-through and hit responses;
- that a read request is always a single-cycle pulse;
- that a fault response carries the walked address in `fault_addr`;
- that a lookup right after a flush never hits.

Only the scenarios can show the rest:
- the address arithmetic of both reads and the composed physical address;
- the number of reads per outcome;
- that faults leave the cache untouched;
- the round-robin eviction order across 33 distinct pages.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int PN_W   = ADDR_W - OFF_W;

    typedef struct packed {
        logic [IDX_W-1:0] dir;
        logic [IDX_W-1:0] tbl;
        logic [OFF_W-1:0] off;
    } lin_addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PDE_RD,
        ST_PDE_WT,
        ST_PTE_RD,
        ST_PTE_WT
    } walk_st_t;

    typedef struct packed {
        logic            valid;
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] ppn;
    } xlat_ent_t;

    // Address of a 4-byte entry inside a 4 KB table.
    function automatic logic [ADDR_W-1:0] entry_addr(input logic [PN_W-1:0] base,
                                                     input logic [IDX_W-1:0] idx);
        return {base, idx, 2'b00};
    endfunction
endpackage

// File: rtl/pw_xlat_cache.sv
module pw_xlat_cache
    import pw_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [PN_W-1:0] lk_vpn,
    output logic            lk_hit,
    output logic [PN_W-1:0] lk_ppn,
    input  logic            fill_en,
    input  logic [PN_W-1:0] fill_vpn,
    input  logic [PN_W-1:0] fill_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    xlat_ent_t        ents [ENTRIES];
    logic [PTR_W-1:0] ptr;
    logic [ENTRIES-1:0] match;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = ents[g].valid && (ents[g].vpn == lk_vpn);
        end
    endgenerate

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_ppn = lk_ppn | ents[i].ppn;
        end
    end
    assign lk_hit = |match;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < ENTRIES; i++) ents[i].valid <= 1'b0;
            ptr <= '0;
        end else if (fill_en) begin
            ents[ptr] <= '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn};
            ptr       <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R8: after a flush nothing can hit
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);
endmodule

// File: rtl/pw_walker.sv
module pw_walker
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] lin,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              done,
    output logic              fault,
    output logic [PN_W-1:0]   ppn,
    output logic [ADDR_W-1:0] walk_lin
);
    walk_st_t        st;
    lin_addr_t       lin_q;
    logic [PN_W-1:0] tbl_base;
    logic            present;
    logic            unused_bits;

    assign unused_bits = ^{dir_base[OFF_W-1:0], mem_rd_data[OFF_W-1:1]};
    assign present     = mem_rd_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            lin_q    <= '0;
            tbl_base <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    lin_q <= lin_addr_t'(lin);
                    st    <= ST_PDE_RD;
                end
                ST_PDE_RD: st <= ST_PDE_WT;
                ST_PDE_WT: if (mem_rd_valid) begin
                    if (present) begin
                        tbl_base <= mem_rd_data[ADDR_W-1:OFF_W];
                        st       <= ST_PTE_RD;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_PTE_RD: st <= ST_PTE_WT;
                ST_PTE_WT: if (mem_rd_valid) st <= ST_IDLE;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign mem_rd_en = (st == ST_PDE_RD) || (st == ST_PTE_RD);
    assign mem_rd_addr = (st == ST_PDE_RD)
                       ? entry_addr(dir_base[ADDR_W-1:OFF_W], lin_q.dir)
                       : entry_addr(tbl_base, lin_q.tbl);

    assign done  = (st == ST_PTE_WT) && mem_rd_valid && present;
    assign fault = ((st == ST_PDE_WT) || (st == ST_PTE_WT)) && mem_rd_valid && !present;
    assign ppn      = mem_rd_data[ADDR_W-1:OFF_W];
    assign walk_lin = lin_q;

    // R9: every read request lasts exactly one cycle
    a_r9_rd_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);
endmodule

// File: rtl/pw_translator.sv
module pw_translator
    import pw_pkg::*;
#(
    parameter int TLB_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        paging_en,
    input  logic [31:0] dir_base,
    input  logic        flush,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_lin,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [31:0] rsp_phys,
    output logic [31:0] fault_addr,
    output logic        mem_rd_en,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_valid,
    input  logic [31:0] mem_rd_data
);
    logic            accept, walk_busy, walk_start, walk_done, walk_fault;
    logic            hit;
    logic [PN_W-1:0] hit_ppn, walk_ppn;
    logic [31:0]     walk_lin;

    assign req_ready  = !walk_busy;
    assign accept     = req_valid && req_ready;
    assign walk_start = accept && paging_en && !hit;

    pw_xlat_cache #(.ENTRIES(TLB_ENTRIES)) u_cache (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .lk_vpn   (req_lin[31:OFF_W]),
        .lk_hit   (hit),
        .lk_ppn   (hit_ppn),
        .fill_en  (walk_done),
        .fill_vpn (walk_lin[31:OFF_W]),
        .fill_ppn (walk_ppn)
    );

    pw_walker u_walk (
        .clk          (clk),
        .rst          (rst),
        .start        (walk_start),
        .lin          (req_lin),
        .dir_base     (dir_base),
        .busy         (walk_busy),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .done         (walk_done),
        .fault        (walk_fault),
        .ppn          (walk_ppn),
        .walk_lin     (walk_lin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_phys   <= '0;
            fault_addr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            if (accept && !paging_en) begin
                rsp_valid <= 1'b1;
                rsp_phys  <= req_lin;
            end else if (accept && hit) begin
                rsp_valid <= 1'b1;
                rsp_phys  <= {hit_ppn, req_lin[OFF_W-1:0]};
            end else if (walk_done) begin
                rsp_valid <= 1'b1;
                rsp_phys  <= {walk_ppn, walk_lin[OFF_W-1:0]};
            end else if (walk_fault) begin
                rsp_valid  <= 1'b1;
                rsp_fault  <= 1'b1;
                rsp_phys   <= '0;
                fault_addr <= walk_lin;
            end
        end
    end

    // R1: pass-through answers next cycle with the same address
    a_r1_passthru: assert property (@(posedge clk) disable iff (rst)
        (accept && !paging_en) |=> (rsp_valid && !rsp_fault && rsp_phys == $past(req_lin)));

    // R5: a hit answers next cycle and starts no read
    a_r5_hit_fast: assert property (@(posedge clk) disable iff (rst)
        (accept && paging_en && hit) |=> (rsp_valid && !rsp_fault && !mem_rd_en));

    // R6: a walk fault is reported with its linear address captured
    a_r6_fault_capture: assert property (@(posedge clk) disable iff (rst)
        walk_fault |=> (rsp_valid && rsp_fault && fault_addr == $past(walk_lin)));
endmodule

// File: tb/pw_translator_tb.sv
module pw_translator_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        paging_en = 1'b0;
    logic [31:0] dir_base = 32'h0010_0ABC;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_phys, fault_addr;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    always #5 clk = ~clk;

    pw_translator u_dut (
        .clk(clk), .rst(rst), .paging_en(paging_en), .dir_base(dir_base),
        .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_phys(rsp_phys), .fault_addr(fault_addr), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data)
    );

    typedef struct {
        logic [31:0] phys;
        logic        fault;
        logic [31:0] lin;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    vectors = 0;
    int    fails = 0;
    int    rd_count = 0;
    bit    finished = 0;
    logic [31:0] mem [logic [31:0]];

    // Memory model: one-cycle read latency; missing words read with bit 0 clear.
    always @(posedge clk) begin
        mem_rd_valid <= mem_rd_en;
        if (mem_rd_en) begin
            rd_count++;
            mem_rd_data <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0000_0FFE;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, expv);
        end
    endtask

    // Monitor: pop the scoreboard on each response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_fault == e.fault, {t, " fault flag"}, {31'd0, rsp_fault}, {31'd0, e.fault});
                if (e.fault)
                    chk(fault_addr == e.lin, {t, " fault_addr"}, fault_addr, e.lin);
                else
                    chk(rsp_phys == e.phys, {t, " phys"}, rsp_phys, e.phys);
            end
        end
    end

    function automatic logic [31:0] mk(input int d, input int t, input int off);
        return {d[9:0], t[9:0], off[11:0]};
    endfunction

    function automatic logic [19:0] frame(input int t);
        return 20'h40000 + 20'(t);
    endfunction

    task automatic xlate(input logic [31:0] lin, input bit pg, input logic [31:0] ephys,
                         input bit efault, input int ereads, input string tag);
        int   base;
        exp_t e;
        paging_en = pg;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.phys = ephys; e.fault = efault; e.lin = lin;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        base = rd_count;
        req_valid = 1'b1;
        req_lin   = lin;
        @(negedge clk);
        req_valid = 1'b0;
        if (ereads == 0)
            chk(rsp_valid == 1'b1, {tag, " one-cycle latency"}, {31'd0, rsp_valid}, 32'd1);
        else
            chk(req_ready == 1'b0, "R9 busy during walk", {31'd0, req_ready}, 32'd0);
        while (exp_q.size() != 0) @(negedge clk);
        chk(rd_count - base == ereads, {tag, " read count"}, rd_count - base, ereads);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        // Directory 1 -> table at 0x00200000; directory 3 -> empty table 0x00201000
        mem[32'h0010_0004] = 32'h0020_0F01;
        mem[32'h0010_000C] = 32'h0020_1001;
        for (int t = 0; t < 40; t++)
            mem[32'h0020_0000 + 32'(t * 4)] = {frame(t), 12'h0E5};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk(mem_rd_en == 1'b0, "R10 mem_rd_en", {31'd0, mem_rd_en}, 32'd0);
        chk(fault_addr == 32'd0, "R10 fault_addr", fault_addr, 32'd0);

        // R1 pass-through
        xlate(32'h1234_5678, 1'b0, 32'h1234_5678, 1'b0, 0, "R1");
        // R2 R3 R4 walk
        xlate(mk(1, 0, 12'h0AB), 1'b1, {frame(0), 12'h0AB}, 1'b0, 2, "R2 R3 R4");
        xlate(mk(1, 7, 12'h3C0), 1'b1, {frame(7), 12'h3C0}, 1'b0, 2, "R4");
        // R5 hit, different offset
        xlate(mk(1, 0, 12'hFFC), 1'b1, {frame(0), 12'hFFC}, 1'b0, 0, "R5");
        // R6 faults at both levels, no fill
        xlate(mk(2, 4, 12'h123), 1'b1, 32'd0, 1'b1, 1, "R6 dir level");
        xlate(mk(3, 5, 12'h456), 1'b1, 32'd0, 1'b1, 2, "R6 table level");
        xlate(mk(3, 5, 12'h789), 1'b1, 32'd0, 1'b1, 2, "R6 not cached");
        xlate(mk(1, 7, 12'h001), 1'b1, {frame(7), 12'h001}, 1'b0, 0, "R5");
        chk(fault_addr == mk(3, 5, 12'h789), "R6 fault_addr holds", fault_addr, mk(3, 5, 12'h789));
        // R1 with cached entries present
        xlate(mk(1, 0, 12'h0AB), 1'b0, mk(1, 0, 12'h0AB), 1'b0, 0, "R1");
        // R8 flush
        do_flush();
        xlate(mk(1, 0, 12'h010), 1'b1, {frame(0), 12'h010}, 1'b0, 2, "R8");
        // R7 round robin
        do_flush();
        for (int t = 0; t < 32; t++)
            xlate(mk(1, t, 12'h020), 1'b1, {frame(t), 12'h020}, 1'b0, 2, "R7 fill");
        xlate(mk(1, 0, 12'h030), 1'b1, {frame(0), 12'h030}, 1'b0, 0, "R7 all 32 held");
        xlate(mk(1, 32, 12'h040), 1'b1, {frame(32), 12'h040}, 1'b0, 2, "R7 evict slot0");
        xlate(mk(1, 1, 12'h050), 1'b1, {frame(1), 12'h050}, 1'b0, 0, "R7 slot1 kept");
        xlate(mk(1, 0, 12'h060), 1'b1, {frame(0), 12'h060}, 1'b0, 2, "R7 oldest evicted");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule